// File: doc/BRIEF.md
# HDLC Receive Frame Acceptance Filter

This block sits behind an HDLC deframer. The deframer handles flag detection, zero-bit removal and CRC computation, and it passes bytes to this block one beat at a time. Each beat carries a data byte and several status flags: byte valid, end of frame, CRC error, overrun and abort. The filter writes accepted bytes into one frame buffer. At each end of frame it makes one decision: commit the stored frame to the consumer, or rewind the buffer and reuse it for the next frame. An error never frees the buffer. It only moves the write position back to address zero.

A committed frame is announced with a one-cycle pulse that carries the payload length. This length is the stored byte count minus the two trailing CRC bytes. The consumer reads the payload through a separate synchronous read port. It must do so before the next frame's bytes overwrite the buffer. Five saturating counters record frames, CRC rejects, overruns, oversize events and aborts.

Within one beat the order is fixed. An abort is taken first. Then the byte is handled. Then the end-of-frame decision is made, using the count and state that result from that byte.

Top module: `hdlc_rx_accept`

## Requirements
- R1: While reset is high and on the first cycle after it, every counter reads zero and `commit` is low.
- R2: A valid byte that arrives in the active state, with no overrun, and while the stored count is below the effective limit, is written at address equal to the stored count. The count then increments.
- R3: An end-of-frame beat with a stored count of at least 10 and no CRC error raises `commit` for exactly one cycle, on the cycle after that beat. `commit_len` equals the count minus 2. The next stored byte goes to address 0.
- R4: An end-of-frame beat with a stored count from 1 to 9 produces no commit and rewinds the buffer to address 0.
- R5: An end-of-frame beat with a nonzero count and the CRC error flag set produces no commit, rewinds the buffer and increments `cnt_crc`.
- R6: A valid byte flagged as overrun is dropped. It rewinds the buffer, increments `cnt_overrun` and enters an error state. The next valid byte is dropped and returns the state to active.
- R7: The effective limit is `size_limit`, clamped to the buffer depth. A valid byte that arrives when the stored count equals the effective limit is dropped. It rewinds the buffer, increments `cnt_toobig` and enters an oversize state. The next valid byte is dropped and returns the state to active.
- R8: An abort beat in the active state rewinds the buffer and increments `cnt_abort`. An abort beat in a non-active state changes nothing. On any abort beat the byte and end-of-frame flags are ignored.
- R9: Every non-abort end-of-frame beat increments `cnt_frames`, including one with no stored bytes, and leaves the state active.
- R10: All counters stop at their all-ones value and never decrease.
- R11: `rd_data` presents the buffer byte at `rd_addr` one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat carries a data byte |
| in_data | input | DATA_W | Received byte |
| in_eof | input | 1 | Beat closes the frame |
| in_crc_err | input | 1 | CRC check failed (read on end-of-frame beats) |
| in_overrun | input | 1 | Deframer overran on this byte |
| in_abort | input | 1 | Abort sequence detected |
| size_limit | input | ADDR_W+1 | Maximum number of stored bytes per frame |
| rd_addr | input | ADDR_W | Consumer read address |
| rd_data | output | DATA_W | Registered read data |
| commit | output | 1 | One-cycle frame accept pulse |
| commit_len | output | ADDR_W+1 | Payload length without CRC, valid with `commit` |
| cnt_frames | output | CNT_W | End-of-frame events |
| cnt_crc | output | CNT_W | CRC-rejected frames |
| cnt_overrun | output | CNT_W | Overrun events |
| cnt_toobig | output | CNT_W | Oversize events |
| cnt_abort | output | CNT_W | Aborts taken in the active state |

## Verification
The hardest case to reach is the one-byte window of the error and oversize states. It can only be seen through the byte after the fault: that byte is dropped, and the following bytes are stored again from address 0. The stimulus places overruns and limit hits at chosen positions inside long frames. The resulting commit length and payload then show exactly which bytes were dropped. An abort that arrives in that window shows whether the abort was ignored, because the abort counter stays unchanged. Clamping the limit needs a `size_limit` larger than the buffer depth and a frame that runs past the buffer's end.

// File: rtl/hdlc_rxa_pkg.sv
package hdlc_rxa_pkg;
  typedef enum logic [1:0] {
    RXS_ACTIVE  = 2'd0,
    RXS_OVERRUN = 2'd1,
    RXS_OVERSZ  = 2'd2
  } rxs_e;

  localparam int EV_FRAME = 0;
  localparam int EV_CRC   = 1;
  localparam int EV_OVR   = 2;
  localparam int EV_BIG   = 3;
  localparam int EV_ABORT = 4;
  localparam int EV_N     = 5;
endpackage

// File: rtl/hdlc_rxa_satcnt.sv
module hdlc_rxa_satcnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [CW-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else if (inc && (q != '1)) q <= q + 1'b1;
  end
endmodule

// File: rtl/hdlc_rxa_ram.sv
module hdlc_rxa_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/hdlc_rxa_ctrl.sv
module hdlc_rxa_ctrl
  import hdlc_rxa_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int MIN_FRAME = 10,
  parameter int CRC_BYTES = 2,
  localparam int LEN_W    = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_eof,
  input  logic              in_crc_err,
  input  logic              in_overrun,
  input  logic              in_abort,
  input  logic [LEN_W-1:0]  size_limit,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              commit,
  output logic [LEN_W-1:0]  commit_len,
  output logic [EV_N-1:0]   evt
);
  localparam logic [LEN_W-1:0] DEPTH_L = LEN_W'(2 ** ADDR_W);
  localparam logic [LEN_W-1:0] MIN_L   = LEN_W'(MIN_FRAME);
  localparam logic [LEN_W-1:0] CRC_L   = LEN_W'(CRC_BYTES);

  rxs_e             st_q, st_n;
  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic [LEN_W-1:0] lim_eff;
  logic             commit_n;
  logic [LEN_W-1:0] len_n;

  assign lim_eff = (size_limit > DEPTH_L) ? DEPTH_L : size_limit;
  assign wr_addr = cnt_q[ADDR_W-1:0];
  assign wr_data = in_data;

  // Beat evaluation: abort first, then the byte, then the end-of-frame decision
  always_comb begin
    st_n     = st_q;
    cnt_n    = cnt_q;
    wr_en    = 1'b0;
    evt      = '0;
    commit_n = 1'b0;
    len_n    = '0;
    if (in_abort) begin
      if (st_q == RXS_ACTIVE) begin
        cnt_n         = '0;
        evt[EV_ABORT] = 1'b1;
      end
    end else begin
      if (in_valid) begin
        if (in_overrun) begin
          cnt_n       = '0;
          st_n        = RXS_OVERRUN;
          evt[EV_OVR] = 1'b1;
        end else if (cnt_q >= lim_eff) begin
          cnt_n       = '0;
          st_n        = RXS_OVERSZ;
          evt[EV_BIG] = 1'b1;
        end else if (st_q != RXS_ACTIVE) begin
          st_n = RXS_ACTIVE;
        end else begin
          wr_en = 1'b1;
          cnt_n = cnt_q + 1'b1;
        end
      end
      if (in_eof) begin
        evt[EV_FRAME] = 1'b1;
        if (cnt_n != '0) begin
          if (in_crc_err || (st_n != RXS_ACTIVE) || (cnt_n < MIN_L)) begin
            evt[EV_CRC] = in_crc_err;
          end else begin
            commit_n = 1'b1;
            len_n    = cnt_n - CRC_L;
          end
        end
        cnt_n = '0;
        st_n  = RXS_ACTIVE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= RXS_ACTIVE;
      cnt_q      <= '0;
      commit     <= 1'b0;
      commit_len <= '0;
    end else begin
      st_q       <= st_n;
      cnt_q      <= cnt_n;
      commit     <= commit_n;
      commit_len <= len_n;
    end
  end
endmodule

// File: rtl/hdlc_rx_accept.sv
module hdlc_rx_accept
  import hdlc_rxa_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 16,
  parameter int MIN_FRAME = 10,
  parameter int CRC_BYTES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_eof,
  input  logic              in_crc_err,
  input  logic              in_overrun,
  input  logic              in_abort,
  input  logic [ADDR_W:0]   size_limit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              commit,
  output logic [ADDR_W:0]   commit_len,
  output logic [CNT_W-1:0]  cnt_frames,
  output logic [CNT_W-1:0]  cnt_crc,
  output logic [CNT_W-1:0]  cnt_overrun,
  output logic [CNT_W-1:0]  cnt_toobig,
  output logic [CNT_W-1:0]  cnt_abort
);
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [EV_N-1:0]   evt;
  logic [CNT_W-1:0]  cnt_q [EV_N];

  hdlc_rxa_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MIN_FRAME(MIN_FRAME), .CRC_BYTES(CRC_BYTES)
  ) u_ctrl (
    .clk, .rst, .in_valid, .in_data, .in_eof, .in_crc_err, .in_overrun, .in_abort,
    .size_limit, .wr_en, .wr_addr, .wr_data, .commit, .commit_len, .evt
  );

  hdlc_rxa_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk, .we(wr_en), .waddr(wr_addr), .wdata(wr_data), .raddr(rd_addr), .rdata(rd_data)
  );

  for (genvar g = 0; g < EV_N; g++) begin : g_cnt
    hdlc_rxa_satcnt #(.CW(CNT_W)) u_cnt (.clk, .rst, .inc(evt[g]), .q(cnt_q[g]));
  end

  assign cnt_frames  = cnt_q[EV_FRAME];
  assign cnt_crc     = cnt_q[EV_CRC];
  assign cnt_overrun = cnt_q[EV_OVR];
  assign cnt_toobig  = cnt_q[EV_BIG];
  assign cnt_abort   = cnt_q[EV_ABORT];
endmodule

// File: rtl/hdlc_rx_accept_chk.sv
module hdlc_rx_accept_chk #(
  parameter int CW      = 16,
  parameter int LW      = 9,
  parameter int MIN_LEN = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_eof,
  input logic          in_overrun,
  input logic          in_abort,
  input logic          commit,
  input logic [LW-1:0] commit_len,
  input logic [CW-1:0] cnt_frames,
  input logic [CW-1:0] cnt_overrun,
  input logic [CW-1:0] cnt_abort
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (cnt_frames == '0) && !commit); // R1
  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) commit |=> !commit); // R3
  AST_COMMIT_MIN_LEN: assert property (@(posedge clk) disable iff (rst) commit |-> (commit_len >= LW'(MIN_LEN))); // R4
  AST_OVERRUN_COUNT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_overrun && !in_abort && (cnt_overrun != '1)) |=> (cnt_overrun == CW'($past(cnt_overrun) + 1'b1))); // R6
  AST_ABORT_NO_FRAME: assert property (@(posedge clk) disable iff (rst)
    in_abort |=> (cnt_frames == $past(cnt_frames))); // R8
  AST_EOF_COUNT: assert property (@(posedge clk) disable iff (rst)
    (in_eof && !in_abort && (cnt_frames != '1)) |=> (cnt_frames == CW'($past(cnt_frames) + 1'b1))); // R9
  AST_FRAMES_SATURATE: assert property (@(posedge clk) disable iff (rst)
    ($past(cnt_frames) == '1) |-> (cnt_frames == '1)); // R10
  AST_ABORT_NO_DECREASE: assert property (@(posedge clk) disable iff (rst)
    cnt_abort >= $past(cnt_abort)); // R10
endmodule

bind hdlc_rx_accept hdlc_rx_accept_chk #(
  .CW(CNT_W), .LW(ADDR_W + 1), .MIN_LEN(MIN_FRAME - CRC_BYTES)
) u_chk (.*);

// File: tb/test_hdlc_rx_accept.sv
`timescale 1ns/1ps
module test_hdlc_rx_accept;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;
  localparam int CW = 6;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 0, in_eof = 0, in_crc_err = 0, in_overrun = 0, in_abort = 0;
  logic [7:0] in_data = '0;
  logic [AW:0] size_limit = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic commit;
  logic [AW:0] commit_len;
  logic [CW-1:0] cnt_frames, cnt_crc, cnt_overrun, cnt_toobig, cnt_abort;

  hdlc_rx_accept #(.DATA_W(8), .ADDR_W(AW), .CNT_W(CW)) i_hdlc_rx_accept (.*);

  always #2.5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  int m_cnt = 0, m_lim = DEPTH;
  bit m_err = 0;
  logic [7:0] m_buf [DEPTH];
  logic [7:0] exp_frame [DEPTH];
  int m_frm = 0, m_crc = 0, m_ovr = 0, m_big = 0, m_abt = 0;
  int pend_len = 0;
  bit got = 0;

  function automatic int bump(int v);
    return (v < CMAX) ? v + 1 : v;
  endfunction

  function automatic int eff_lim(int l);
    return (l > DEPTH) ? DEPTH : l;
  endfunction

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic beat(input bit v, input logic [7:0] d, input bit e,
                      input bit crc, input bit ovr, input bit abt);
    bit ec = 0;
    int el = 0;
    @(negedge clk);
    in_valid = v; in_data = d; in_eof = e; in_crc_err = crc; in_overrun = ovr; in_abort = abt;
    if (abt) begin
      if (!m_err) begin m_cnt = 0; m_abt = bump(m_abt); end
    end else begin
      if (v) begin
        if (ovr) begin m_cnt = 0; m_err = 1; m_ovr = bump(m_ovr); end
        else if (m_cnt >= eff_lim(m_lim)) begin m_cnt = 0; m_err = 1; m_big = bump(m_big); end
        else if (m_err) m_err = 0;
        else begin m_buf[m_cnt] = d; m_cnt++; end
      end
      if (e) begin
        m_frm = bump(m_frm);
        if (m_cnt > 0) begin
          if (crc || m_err || m_cnt < 10) begin
            if (crc) m_crc = bump(m_crc);
          end else begin
            ec = 1; el = m_cnt - 2;
          end
        end
        m_cnt = 0; m_err = 0;
      end
    end
    @(posedge clk); #1;
    check("R3 commit pulse", int'(commit), int'(ec));
    if (ec) begin
      check("R3 commit length", int'(commit_len), el);
      pend_len = el;
      for (int i = 0; i < el; i++) exp_frame[i] = m_buf[i];
      got = 1;
    end
    in_valid = 0; in_eof = 0; in_crc_err = 0; in_overrun = 0; in_abort = 0;
  endtask

  task automatic read_frame();
    for (int i = 0; i < pend_len; i++) begin
      @(negedge clk); rd_addr = AW'(i);
      @(posedge clk); #1;
      check("R2/R11 payload byte", int'(rd_data), int'(exp_frame[i]));
    end
  endtask

  task automatic check_counters(string tag);
    check({tag, " R9 cnt_frames"}, int'(cnt_frames), m_frm);
    check({tag, " R5 cnt_crc"}, int'(cnt_crc), m_crc);
    check({tag, " R6 cnt_overrun"}, int'(cnt_overrun), m_ovr);
    check({tag, " R7 cnt_toobig"}, int'(cnt_toobig), m_big);
    check({tag, " R8 cnt_abort"}, int'(cnt_abort), m_abt);
  endtask

  // ovr_at / abt_at: byte index that carries the flag, -1 for none
  task automatic send_frame(string tag, int n, bit crc, int ovr_at, int abt_at);
    got = 0;
    for (int i = 0; i < n; i++)
      beat(1, 8'($urandom), i == n - 1, crc && (i == n - 1), i == ovr_at, i == abt_at);
    if (got) read_frame();
    check_counters(tag);
  endtask

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    size_limit = (AW+1)'(DEPTH); m_lim = DEPTH;
    repeat (3) @(posedge clk);
    #1;
    check("R1 commit in reset", int'(commit), 0);
    check("R1 cnt_frames in reset", int'(cnt_frames), 0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    check_counters("R1");
    check("R1 commit after reset", int'(commit), 0);

    send_frame("R2 R3 good12", 12, 0, -1, -1);
    check("R3 length of good12", pend_len, 10);
    send_frame("R4 short9", 9, 0, -1, -1);
    send_frame("R4 exact10", 10, 0, -1, -1);
    send_frame("R5 crc14", 14, 1, -1, -1);
    send_frame("R6 ovr", 15, 0, 3, -1);
    check("R6 length after overrun", pend_len, 8);
    m_lim = 16; size_limit = 7'd16;
    send_frame("R7 big", 30, 0, -1, -1);
    check("R7 length after limit", pend_len, 10);
    m_lim = 100; size_limit = 7'd100;
    send_frame("R7 clamp", 70, 0, -1, -1);
    m_lim = DEPTH; size_limit = (AW+1)'(DEPTH);
    send_frame("R8 abort", 20, 0, -1, 5);
    check("R8 length after abort", pend_len, 12);
    // abort while in error state: no count, then flag-driven drop
    beat(1, 8'h11, 0, 0, 1, 0);
    beat(0, 8'h00, 0, 0, 0, 1);
    check_counters("R8 abort ignored");
    beat(0, 8'h00, 1, 0, 0, 0);
    check_counters("R9 empty eof");
    // abort beat with eof flag set is ignored
    beat(1, 8'h22, 1, 0, 0, 1);
    check_counters("R8 abort eof");

    for (int k = 0; k < 70; k++) begin
      int n = 1 + int'($urandom_range(44));
      int ov = ($urandom_range(3) == 0) ? int'($urandom_range(n - 1)) : -1;
      int ab = ($urandom_range(4) == 0 && n > 2) ? int'($urandom_range(n - 2)) : -1;
      m_lim = 24 + int'($urandom_range(16)); size_limit = (AW+1)'(m_lim);
      send_frame("rand", n, $urandom_range(3) == 0, ov, ab);
    end
    check("R10 cnt_frames saturated", int'(cnt_frames), CMAX);
    beat(0, 8'h00, 1, 0, 0, 0);
    check("R10 cnt_frames held", int'(cnt_frames), CMAX);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule